// File: doc/BRIEF.md
# Paged Write Cache Controller

This block gathers a burst of byte writes into a small cache of eight pages, each eight bytes wide, and then commits the loaded pages one by one to a byte-addressed memory array. Each committed page costs a fixed-length timed write cycle. A burst opens with a start strobe that carries a 13-bit array address. The low three bits of that address set where the first byte lands inside cache page 0. Bytes are then presented one per cycle with a valid flag. A stop strobe ends the burst and begins the commit.

During the commit, cache page k goes to array page (start page + k), taken modulo the 1024 pages of the 8 KB array. The array write port carries the page number, 64 bits of page data and an 8-bit byte-enable mask that holds only the positions actually loaded. A one-cycle write strobe opens each page's write cycle. Pages with no loaded bytes are skipped. While a commit is running the block raises busy and ignores every input.

The sequencer has four states:
- `ST_IDLE` waits for start and moves to `ST_LOAD`.
- In `ST_LOAD`, a start restarts the burst and stays in `ST_LOAD`. A stop moves to `ST_WRITE` when some page is loaded, or back to `ST_IDLE` when none is.
- `ST_WRITE` issues the strobe for one cycle and always moves to `ST_HOLD`.
- `ST_HOLD` waits out the rest of the write cycle. It then moves to `ST_WRITE` for the next loaded page, or to `ST_IDLE` after the last one.

Top module: `pgcache_ctrl`

## Requirements
- R1: The first byte after a start is stored in cache page 0 at byte position start_addr[2:0]. Each following valid byte goes to the next cache position, where position = 8 × page + byte.
- R2: After cache position 63, loading wraps to position 0 and overwrites the byte stored there, keeping the newest value.
- R3: A stop accepted in `ST_LOAD` with at least one byte loaded raises busy_o in the next cycle. Any data byte presented in the same cycle as the stop is discarded.
- R4: Cache page k is written to array page (start_addr[12:3] + k) mod 1024. Byte i of the page is carried on wr_data_o[8i+7:8i].
- R5: Only pages holding at least one loaded byte are written, in ascending k. wr_be_o bit i is 1 exactly when byte i of that page was loaded in the current burst.
- R6: Each page write cycle lasts WRITE_CYCLES clocks. wr_en_o pulses for one clock at the start of each cycle, so consecutive pulses are WRITE_CYCLES clocks apart. busy_o is high for exactly (pages written) × WRITE_CYCLES clocks and is low in the clock after the last cycle ends.
- R7: While busy_o is high, start_i, data_valid_i and stop_i have no effect on the array contents or on the commit in progress.
- R8: A stop with no bytes loaded produces no write strobe, and busy_o stays low.
- R9: A start clears every loaded-byte mark. A start during loading restarts the burst at the new address, and bytes from the abandoned burst are never written.
- R10: After reset, busy_o and wr_en_o are low and no bytes are marked as loaded.
- R11: In `ST_IDLE`, data_valid_i and stop_i are ignored: no strobe follows and no byte is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin (or restart) a burst |
| start_addr_i | input | 13 | Array byte address of the first byte |
| data_valid_i | input | 1 | data_i carries a byte this cycle |
| data_i | input | 8 | Byte to load |
| stop_i | input | 1 | End the burst and commit the cache |
| busy_o | output | 1 | A commit is in progress |
| wr_en_o | output | 1 | One-cycle array write strobe |
| wr_page_o | output | 10 | Array page number for the write |
| wr_data_o | output | 64 | Page data, byte i on bits 8i+7:8i |
| wr_be_o | output | 8 | Byte enables for the write |

## Verification
On every cycle, the embedded assertions check the following:
- each strobe is a single cycle followed by more busy time;
- no strobe carries an empty byte mask;
- the hold state always has write time left to run;
- a stop on an empty cache never raises busy;
- a start clears the marks;
- each accepted byte sets its mark;
- the burst base stays frozen while busy.

The placement of bytes, wrap-around and overwriting, the mapping of pages to array pages across the top of the array, and the exact busy length all depend on whole bursts. Only the bench can show them. It sweeps every start offset against many burst lengths, compares a modelled array byte for byte, and injects inputs during commits and restarts in the middle of a burst.

// File: rtl/pgcache_pkg.sv
package pgcache_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_WRITE = 2'd2,
        ST_HOLD  = 2'd3
    } pgc_state_e;
endpackage

// File: rtl/pgc_cache.sv
module pgc_cache #(
    parameter int PAGES      = 8,
    parameter int PAGE_BYTES = 8
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      clr_i,
    input  logic                                      wr_i,
    input  logic [$clog2(PAGES*PAGE_BYTES)-1:0]       slot_i,
    input  logic [7:0]                                byte_i,
    input  logic [$clog2(PAGES)-1:0]                  rd_page_i,
    output logic [PAGE_BYTES*8-1:0]                   rd_data_o,
    output logic [PAGE_BYTES-1:0]                     rd_mask_o,
    output logic [PAGES*PAGE_BYTES-1:0]               masks_o
);
    localparam int CACHE_BYTES = PAGES * PAGE_BYTES;
    localparam int SLOT_W      = $clog2(CACHE_BYTES);
    localparam int OFF_W       = $clog2(PAGE_BYTES);

    logic [7:0]             bytes_q [CACHE_BYTES];
    logic [CACHE_BYTES-1:0] vmask_q;

    always_ff @(posedge clk) begin
        if (wr_i) begin
            bytes_q[slot_i] <= byte_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vmask_q <= '0;
        end else if (clr_i) begin
            vmask_q <= '0;
        end else if (wr_i) begin
            vmask_q[slot_i] <= 1'b1;
        end
    end

    generate
        for (genvar b = 0; b < PAGE_BYTES; b++) begin : g_rd
            logic [SLOT_W-1:0] rd_slot;
            assign rd_slot = {rd_page_i, OFF_W'(b)};
            assign rd_data_o[b*8 +: 8] = bytes_q[rd_slot];
            assign rd_mask_o[b]        = vmask_q[rd_slot];
        end
    endgenerate

    assign masks_o = vmask_q;

    // R9: a start leaves no byte marked
    assert_clear_masks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (masks_o == '0));

    // R1: an accepted byte is marked at its slot
    assert_byte_marked_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !clr_i) |=> masks_o[$past(slot_i)]);
endmodule

// File: rtl/pgc_pick.sv
module pgc_pick #(
    parameter int PAGES      = 8,
    parameter int PAGE_BYTES = 8
) (
    input  logic [PAGES*PAGE_BYTES-1:0] masks_i,
    input  logic [$clog2(PAGES):0]      from_i,
    output logic                        found_o,
    output logic [$clog2(PAGES)-1:0]    idx_o
);
    localparam int PG_W = $clog2(PAGES);

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int p = PAGES - 1; p >= 0; p--) begin
            if (((PG_W + 1)'(p) >= from_i) && (|masks_i[p*PAGE_BYTES +: PAGE_BYTES])) begin
                found_o = 1'b1;
                idx_o   = PG_W'(p);
            end
        end
    end
endmodule

// File: rtl/pgc_timer.sv
module pgc_timer #(
    parameter int WRITE_CYCLES = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              load_i,
    output logic                              last_o,
    output logic [$clog2(WRITE_CYCLES+1)-1:0] cnt_o
);
    localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= CNT_W'(WRITE_CYCLES - 1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last_o = (cnt_q == CNT_W'(1));
    assign cnt_o  = cnt_q;
endmodule

// File: rtl/pgcache_ctrl.sv
module pgcache_ctrl #(
    parameter int PAGES        = 8,
    parameter int PAGE_BYTES   = 8,
    parameter int ADDR_W       = 13,
    parameter int WRITE_CYCLES = 250000
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  start_i,
    input  logic [ADDR_W-1:0]                     start_addr_i,
    input  logic                                  data_valid_i,
    input  logic [7:0]                            data_i,
    input  logic                                  stop_i,
    output logic                                  busy_o,
    output logic                                  wr_en_o,
    output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0]  wr_page_o,
    output logic [PAGE_BYTES*8-1:0]               wr_data_o,
    output logic [PAGE_BYTES-1:0]                 wr_be_o
);
    import pgcache_pkg::*;

    localparam int CACHE_BYTES = PAGES * PAGE_BYTES;
    localparam int SLOT_W      = $clog2(CACHE_BYTES);
    localparam int OFF_W       = $clog2(PAGE_BYTES);
    localparam int PG_W        = $clog2(PAGES);
    localparam int APAGE_W     = ADDR_W - OFF_W;
    localparam int CNT_W       = $clog2(WRITE_CYCLES + 1);

    pgc_state_e         state_q, state_d;
    logic [SLOT_W-1:0]  slot_q;
    logic [APAGE_W-1:0] base_q;
    logic [PG_W-1:0]    pg_q;

    logic               take_start, take_byte;
    logic               tmr_load, tmr_last;
    logic [CNT_W-1:0]   tmr_cnt;
    logic [PG_W:0]      pick_from;
    logic               pick_found;
    logic [PG_W-1:0]    pick_idx;
    logic [CACHE_BYTES-1:0] masks;

    // ---------------- next-state logic ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_LOAD;
            ST_LOAD: begin
                if (start_i)      state_d = ST_LOAD;
                else if (stop_i)  state_d = pick_found ? ST_WRITE : ST_IDLE;
            end
            ST_WRITE: state_d = ST_HOLD;
            ST_HOLD: begin
                if (tmr_last) state_d = pick_found ? ST_WRITE : ST_IDLE;
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    // ---------------- state and datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
            base_q  <= '0;
            pg_q    <= '0;
        end else begin
            state_q <= state_d;
            if (take_start) begin
                base_q <= start_addr_i[ADDR_W-1:OFF_W];
                slot_q <= SLOT_W'(start_addr_i[OFF_W-1:0]);
            end else if (take_byte) begin
                slot_q <= slot_q + 1'b1;
            end
            if (state_d == ST_WRITE && state_q != ST_WRITE) begin
                pg_q <= pick_idx;
            end
        end
    end

    // ---------------- control outputs ----------------
    always_comb begin
        take_start = 1'b0;
        take_byte  = 1'b0;
        tmr_load   = 1'b0;
        busy_o     = 1'b0;
        wr_en_o    = 1'b0;
        pick_from  = '0;
        unique case (state_q)
            ST_IDLE:  take_start = start_i;
            ST_LOAD: begin
                take_start = start_i;
                take_byte  = data_valid_i && !start_i && !stop_i;
            end
            ST_WRITE: begin
                wr_en_o  = 1'b1;
                busy_o   = 1'b1;
                tmr_load = 1'b1;
            end
            ST_HOLD: begin
                busy_o    = 1'b1;
                pick_from = {1'b0, pg_q} + (PG_W + 1)'(1);
            end
            default: ;
        endcase
    end

    pgc_cache #(.PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES)) u_cache (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (take_start),
        .wr_i      (take_byte),
        .slot_i    (slot_q),
        .byte_i    (data_i),
        .rd_page_i (pg_q),
        .rd_data_o (wr_data_o),
        .rd_mask_o (wr_be_o),
        .masks_o   (masks)
    );

    pgc_pick #(.PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES)) u_pick (
        .masks_i (masks),
        .from_i  (pick_from),
        .found_o (pick_found),
        .idx_o   (pick_idx)
    );

    pgc_timer #(.WRITE_CYCLES(WRITE_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .last_o (tmr_last),
        .cnt_o  (tmr_cnt)
    );

    assign wr_page_o = base_q + APAGE_W'(pg_q);

    // ---------------- assertions ----------------
    assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> (!wr_en_o && busy_o));

    assert_hold_has_time_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> (tmr_cnt != '0));

    assert_no_empty_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (wr_be_o != '0));

    assert_frozen_base_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (base_q == $past(base_q)));

    assert_empty_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD && stop_i && !start_i && masks == '0) |=> !busy_o);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> !wr_en_o);
endmodule

// File: tb/tb_pgcache_ctrl.sv
module tb_pgcache_ctrl;
    localparam int WC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [12:0] start_addr_i = '0;
    logic        data_valid_i = 1'b0;
    logic [7:0]  data_i = '0;
    logic        stop_i = 1'b0;
    logic        busy_o, wr_en_o;
    logic [9:0]  wr_page_o;
    logic [63:0] wr_data_o;
    logic [7:0]  wr_be_o;

    always #10 clk = ~clk;

    pgcache_ctrl #(.WRITE_CYCLES(WC)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
        .data_valid_i(data_valid_i), .data_i(data_i), .stop_i(stop_i),
        .busy_o(busy_o), .wr_en_o(wr_en_o), .wr_page_o(wr_page_o),
        .wr_data_o(wr_data_o), .wr_be_o(wr_be_o)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;
    logic [7:0] act_mem [8192];
    logic [7:0] exp_mem [8192];
    int cyc = 0;
    int strobes = 0;
    int last_strobe = 0;
    bit spacing_arm = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // array model and strobe spacing monitor
    always @(negedge clk) begin
        cyc++;
        if (rst_n && wr_en_o) begin
            for (int i = 0; i < 8; i++)
                if (wr_be_o[i]) act_mem[{wr_page_o, 3'(i)}] = wr_data_o[8*i +: 8];
            if (spacing_arm) check((cyc - last_strobe) == WC, "R6 strobe spacing", cyc - last_strobe, WC);
            spacing_arm = 1'b1;
            last_strobe = cyc;
            strobes++;
        end
    end

    task automatic compare_mem(input string req);
        int bad = 0;
        for (int a = 0; a < 8192; a++) if (act_mem[a] !== exp_mem[a]) bad++;
        check(bad == 0, req, bad, 0);
    endtask

    task automatic burst(input int addr, input int n, input int id, input bit noise, input int pre_n);
        bit [7:0] sval [64];
        bit       sld  [64];
        int       pages, sc0, busy_cnt, guard, exp_busy;
        for (int s = 0; s < 64; s++) begin sval[s] = 0; sld[s] = 0; end
        if (pre_n > 0) begin          // R9: abandoned burst
            start_i = 1; start_addr_i = 13'((addr + 2048 + 5) % 8192);
            @(negedge clk); start_i = 0;
            for (int j = 0; j < pre_n; j++) begin
                data_valid_i = 1; data_i = 8'(8'hA5 ^ j); @(negedge clk);
            end
            data_valid_i = 0;
        end
        start_i = 1; start_addr_i = 13'(addr);
        @(negedge clk); start_i = 0;
        for (int j = 0; j < n; j++) begin
            int s = ((addr % 8) + j) % 64;   // R1 placement, R2 wrap
            data_valid_i = 1; data_i = 8'(id * 7 + j * 13 + 1);
            sval[s] = 8'(id * 7 + j * 13 + 1); sld[s] = 1;
            @(negedge clk);
        end
        data_valid_i = 0;
        pages = 0;
        for (int k = 0; k < 8; k++) begin
            bit any = 0;
            for (int b = 0; b < 8; b++) if (sld[k*8+b]) begin
                any = 1;
                exp_mem[(((addr / 8) + k) % 1024) * 8 + b] = sval[k*8+b]; // R4
            end
            if (any) pages++;
        end
        exp_busy = pages * WC;
        spacing_arm = 0;
        sc0 = strobes;
        stop_i = 1; data_valid_i = 1; data_i = 8'hEE;   // R3: byte with stop discarded
        @(negedge clk);
        stop_i = 0; data_valid_i = 0;
        check(busy_o == (pages > 0), "R3/R8 busy after stop", int'(busy_o), int'(pages > 0));
        busy_cnt = 0; guard = 0;
        while (busy_o && guard < 1000) begin
            busy_cnt++; guard++;
            if (noise && busy_cnt < exp_busy) begin      // R7 ignored inputs
                start_i = 1; start_addr_i = 13'(busy_cnt * 97); data_valid_i = 1;
                data_i = 8'h5A; stop_i = 1;
            end else begin
                start_i = 0; data_valid_i = 0; stop_i = 0;
            end
            @(negedge clk);
        end
        start_i = 0; data_valid_i = 0; stop_i = 0;
        @(negedge clk);
        check(busy_cnt == exp_busy, "R6 busy length", busy_cnt, exp_busy);
        check((strobes - sc0) == pages, "R5 pages written", strobes - sc0, pages);
        compare_mem(noise ? "R7/R4 array after noisy commit" : "R1/R2/R4/R5 array contents");
    endtask

    initial begin
        int lens [9] = '{1, 3, 8, 9, 17, 63, 64, 65, 71};
        int id = 0;
        for (int a = 0; a < 8192; a++) begin act_mem[a] = 0; exp_mem[a] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(!busy_o && !wr_en_o, "R10 reset state", int'(busy_o), 0);
        // R11: idle inputs ignored
        data_valid_i = 1; data_i = 8'h33; @(negedge clk);
        stop_i = 1; @(negedge clk);
        stop_i = 0; data_valid_i = 0;
        repeat (WC + 2) begin
            @(negedge clk);
            check(!busy_o, "R11 idle stop ignored", int'(busy_o), 0);
        end
        check(strobes == 0, "R11/R10 no strobe from idle", strobes, 0);
        // R8: empty burst
        start_i = 1; start_addr_i = 13'd100; @(negedge clk); start_i = 0;
        stop_i = 1; @(negedge clk); stop_i = 0;
        repeat (3) begin
            check(!busy_o, "R8 empty stop busy", int'(busy_o), 0);
            @(negedge clk);
        end
        check(strobes == 0, "R8 empty stop strobes", strobes, 0);
        // top-of-array wrap, R4
        burst(1022 * 8 + 3, 64, 200, 0, 0);
        burst(1023 * 8, 24, 201, 1, 4);
        // offset x length sweep
        for (int off = 0; off < 8; off++) begin
            for (int li = 0; li < 9; li++) begin
                int pg = (off * 131 + li * 37 + 1000) % 1024;
                burst(pg * 8 + off, lens[li], id, bit'((off + li) % 2), (li % 3 == 0) ? 5 : 0);
                id++;
            end
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule